// File: doc/BRIEF.md
# Step-Mode DMA Channel

This block is one DMA channel that serves a peripheral in step mode. Each transfer request from the peripheral moves exactly one block of data. The channel asks for the system bus, waits for the grant and then spends one cycle loading its working copy of the descriptor from internal storage. It then copies the block one unit at a time, as a read from the source followed by a write to the destination. After the last unit it drops its bus request, so the processor gets the data bus back before the next block can start.

The descriptor lives in a small register file that the processor writes. The file holds a source address, a destination address, a block size and a remaining transfer count, plus a control word. The control word enables the channel and chooses how the request line is sensed. In edge mode a rising edge is latched as one pending request. In level mode the channel starts a new block whenever it is idle and the line is high. After every block the channel writes the advanced addresses and the reduced count back into the register file. When the count reaches zero the channel disables itself and raises a completion flag.

Top module: `stepdma_channel`

## Requirements
- R1: In edge mode, one rising edge of `dreq` produces exactly one block. With no further edge the channel stays idle and `bus_req` does not rise again.
- R2: In level mode, the channel starts a block each time it is idle, enabled and `dreq` is high. A held-high `dreq` runs successive blocks until the count is used up.
- R3: After the last write of every block, `bus_req` is low in the cycle where `dack` falls. Every block therefore begins with a fresh rising edge of `bus_req`.
- R4: A block moves min(B, C) units, where C is the remaining count and B is the block size. A block size of 0 is treated as 1.
- R5: Once `bus_gnt` is seen, the channel spends one cycle loading the descriptor, with `dack` high and no bus read or write. `dack` then stays high through the last write of the block, and `dack` is only ever high while `bus_req` is high.
- R6: Until `bus_gnt` is high, the channel holds `bus_req` high, keeps `dack` low and issues no bus access. The pending block is kept and runs once the grant arrives.
- R7: In edge mode, rising edges that arrive while a block is being served are remembered as one single further request. Any number of such edges yields exactly one more block.
- R8: The count drops by the number of units moved in each block. When it reaches zero the channel clears its enable and sets `done`. `dreq` then has no effect: `bus_req` stays low.
- R9: While `busy` is high (from the request until the write-back cycle), writes to the register file are ignored. The next block then continues from the addresses the channel advanced itself.
- R10: Each unit is a read at the current source address, then a write of that same data to the current destination address. Both addresses advance by UNIT_BYTES per unit and carry on from one block to the next.
- R11: Register select codes on `cfg_sel` are 0 source address, 1 destination address, 2 block size, 3 count and 4 control. In the control word, bit 0 enables the channel and bit 1 selects edge mode (1) or level mode (0). Writing the control word clears `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register file write strobe |
| cfg_sel | input | 3 | Register select (R11 encoding) |
| cfg_wdata | input | AW | Register write data |
| dreq | input | 1 | Transfer request from the peripheral |
| dack | output | 1 | Request being served |
| busy | output | 1 | Channel active; register writes blocked |
| done | output | 1 | Count used up; channel disabled |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_addr | output | AW | Byte address of the current access |
| bus_rd | output | 1 | Read access |
| bus_wr | output | 1 | Write access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack during a read |
| bus_ack | input | 1 | Current access completes this cycle |

## Verification
The assertions check the handshake on every cycle:
- no access without grant;
- `dack` only under `bus_req`, with `bus_req` low when `dack` falls;
- a write always preceded by a read;
- the descriptor cycle free of bus traffic;
- the unit counter within the block size;
- blocked writes leaving the register file unchanged;
- a completed channel staying off the bus.

The assertions also check that the edge latch holds a pending request and is cleared once the request is accepted. Only the bench's scenarios can show the rest. These are that the right number of units moves per block and that the data arrives at the right destination words. They also include merging several edges into one extra block, level-mode repetition up to completion, and address continuity after a blocked write.

// File: rtl/stepdma_pkg.sv
package stepdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARB   = 3'd1,
    ST_DESC  = 3'd2,
    ST_READ  = 3'd3,
    ST_WRITE = 3'd4,
    ST_FREE  = 3'd5
  } dma_state_e;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_BLK  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  // Block size as used by the engine: zero counts as one unit.
  function automatic logic [31:0] eff_block(input logic [31:0] blk);
    return (blk == 32'd0) ? 32'd1 : blk;
  endfunction

  // Units moved by one request: block size capped by what remains.
  function automatic logic [31:0] block_units(input logic [31:0] blk,
                                              input logic [31:0] remaining);
    logic [31:0] e;
    e = eff_block(blk);
    return (e < remaining) ? e : remaining;
  endfunction

endpackage

// File: rtl/stepdma_reqdet.sv
module stepdma_reqdet (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic edge_mode,
  input  logic enable,
  input  logic accept,
  output logic want
);

  logic dreq_q;
  logic pend;
  logic rise;

  assign rise = dreq && !dreq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      dreq_q <= dreq;
      if (!enable) pend <= 1'b0;
      else         pend <= (edge_mode && rise) || (pend && !accept);
    end
  end

  assign want = enable && (edge_mode ? pend : dreq);

  // R7: a latched request survives until the engine accepts it
  assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pend && !accept) |=> pend);

  // R1: an accepted edge request is consumed unless a new edge coincides
  assert_edge_consumed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && edge_mode && accept && !rise) |=> !pend);

endmodule

// File: rtl/stepdma_desc.sv
module stepdma_desc
  import stepdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          wb,
  input  logic [AW-1:0] wb_src,
  input  logic [AW-1:0] wb_dst,
  input  logic [AW-1:0] wb_cnt,
  output logic [AW-1:0] d_src,
  output logic [AW-1:0] d_dst,
  output logic [BW-1:0] d_blk,
  output logic [AW-1:0] d_cnt,
  output logic          enable,
  output logic          edge_mode,
  output logic          done
);

  logic write_ok;
  logic count_spent;

  assign write_ok    = cfg_we && !busy;
  assign count_spent = (wb_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_src     <= '0;
      d_dst     <= '0;
      d_blk     <= '0;
      d_cnt     <= '0;
      enable    <= 1'b0;
      edge_mode <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (write_ok) begin
        case (cfg_sel)
          SEL_SRC:  d_src <= cfg_wdata;
          SEL_DST:  d_dst <= cfg_wdata;
          SEL_BLK:  d_blk <= cfg_wdata[BW-1:0];
          SEL_CNT:  d_cnt <= cfg_wdata;
          SEL_CTRL: begin
            enable    <= cfg_wdata[0];
            edge_mode <= cfg_wdata[1];
            done      <= 1'b0;
          end
          default: ;
        endcase
      end
      if (wb) begin
        d_src <= wb_src;
        d_dst <= wb_dst;
        d_cnt <= wb_cnt;
        if (count_spent) begin
          enable <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R9: a write while the engine is active leaves the file untouched
  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy && !wb) |=>
      $stable({d_src, d_dst, d_blk, d_cnt, enable, edge_mode, done}));

endmodule

// File: rtl/stepdma_engine.sv
module stepdma_engine
  import stepdma_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int BW         = 8,
  parameter int UNIT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want,
  input  logic [AW-1:0] d_src,
  input  logic [AW-1:0] d_dst,
  input  logic [BW-1:0] d_blk,
  input  logic [AW-1:0] d_cnt,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          accept,
  output logic          busy,
  output logic          dack,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          wb,
  output logic [AW-1:0] wb_src,
  output logic [AW-1:0] wb_dst,
  output logic [AW-1:0] wb_cnt
);

  localparam logic [AW-1:0] STEP = AW'(UNIT_BYTES);
  localparam logic [AW-1:0] ONE  = AW'(1);

  dma_state_e state, state_nx;
  logic [AW-1:0] cur_src, cur_dst, left, rem;
  logic [DW-1:0] hold;
  logic [AW-1:0] nblk;

  // named internal events
  logic rd_done, unit_done, last_unit;

  assign nblk      = AW'(block_units(32'(d_blk), 32'(d_cnt)));
  assign rd_done   = (state == ST_READ) && bus_ack;
  assign unit_done = (state == ST_WRITE) && bus_ack;
  assign last_unit = unit_done && (left == ONE);
  assign accept    = (state == ST_ARB) && bus_gnt;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (want) state_nx = ST_ARB;
      ST_ARB:   if (bus_gnt) state_nx = ST_DESC;
      ST_DESC:  state_nx = (nblk == '0) ? ST_FREE : ST_READ;
      ST_READ:  if (rd_done) state_nx = ST_WRITE;
      ST_WRITE: if (unit_done) state_nx = last_unit ? ST_FREE : ST_READ;
      ST_FREE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_src <= '0;
      cur_dst <= '0;
      left    <= '0;
      rem     <= '0;
      hold    <= '0;
    end else begin
      state <= state_nx;
      case (state)
        ST_DESC: begin
          cur_src <= d_src;
          cur_dst <= d_dst;
          left    <= nblk;
          rem     <= d_cnt - nblk;
        end
        ST_READ: if (rd_done) begin
          hold    <= bus_rdata;
          cur_src <= cur_src + STEP;
        end
        ST_WRITE: if (unit_done) begin
          cur_dst <= cur_dst + STEP;
          left    <= left - ONE;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign dack      = (state == ST_DESC) || (state == ST_READ) || (state == ST_WRITE);
  assign bus_req   = (state == ST_ARB) || dack;
  assign bus_rd    = (state == ST_READ);
  assign bus_wr    = (state == ST_WRITE);
  assign bus_addr  = bus_wr ? cur_dst : cur_src;
  assign bus_wdata = hold;
  assign wb        = (state == ST_FREE);
  assign wb_src    = cur_src;
  assign wb_dst    = cur_dst;
  assign wb_cnt    = rem;

  // R5: grant leads to a descriptor cycle with no bus traffic
  assert_desc_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARB && bus_gnt) |=> (dack && !bus_rd && !bus_wr));

  // R6: without a grant nothing reaches the bus in the next cycle
  assert_wait_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !dack) |=> (!bus_rd && !bus_wr));

  // R10: a write is always preceded by the read of its data
  assert_read_then_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd));

  // R4: units still owed never exceed the effective block size
  assert_units_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |-> (left != '0 && 32'(left) <= eff_block(32'(d_blk))));

endmodule

// File: rtl/stepdma_channel.sv
module stepdma_channel #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int BW         = 8,
  parameter int UNIT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          dack,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);

  logic          enable, edge_mode, want, accept, wb;
  logic [AW-1:0] d_src, d_dst, d_cnt, wb_src, wb_dst, wb_cnt;
  logic [BW-1:0] d_blk;

  stepdma_reqdet u_reqdet (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq      (dreq),
    .edge_mode (edge_mode),
    .enable    (enable),
    .accept    (accept),
    .want      (want)
  );

  stepdma_desc #(.AW(AW), .BW(BW)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .wb        (wb),
    .wb_src    (wb_src),
    .wb_dst    (wb_dst),
    .wb_cnt    (wb_cnt),
    .d_src     (d_src),
    .d_dst     (d_dst),
    .d_blk     (d_blk),
    .d_cnt     (d_cnt),
    .enable    (enable),
    .edge_mode (edge_mode),
    .done      (done)
  );

  stepdma_engine #(.AW(AW), .DW(DW), .BW(BW), .UNIT_BYTES(UNIT_BYTES)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .d_src     (d_src),
    .d_dst     (d_dst),
    .d_blk     (d_blk),
    .d_cnt     (d_cnt),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .accept    (accept),
    .busy      (busy),
    .dack      (dack),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wb        (wb),
    .wb_src    (wb_src),
    .wb_dst    (wb_dst),
    .wb_cnt    (wb_cnt)
  );

  // R3: the bus is handed back when service of a block ends
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack) |-> !bus_req);

  // R5: serving only ever happens while the bus is requested
  assert_dack_under_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> bus_req);

  // R6: accesses only under grant
  assert_access_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_gnt);

  // R8: a finished channel stays off the bus
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_req);

endmodule

// File: tb/stepdma_channel_test.sv
`timescale 1ns/100ps
module stepdma_channel_test;

  localparam logic [2:0] K_SRC = 3'd0, K_DST = 3'd1, K_BLK = 3'd2, K_CNT = 3'd3, K_CTRL = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        dreq = 1'b0;
  logic        bus_gnt = 1'b0;
  logic        bus_ack = 1'b0;
  logic        dack, busy, done, bus_req, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  logic [31:0] mem [0:255];
  assign bus_rdata = mem[bus_addr[9:2]];

  int checks = 0, fails = 0;
  int blocks = 0, blk_units = 0, last_units = 0, tot_units = 0, acc_cnt = 0, req_rises = 0;
  logic [15:0] blk_first = 16'd0, last_first = 16'd0;
  bit first_pend = 1'b0, prev_dack = 1'b0, prev_req = 1'b0, gnt_hold = 1'b0, finished = 1'b0;

  stepdma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .dack(dack), .busy(busy), .done(done), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #2 clk = ~clk;

  function automatic int eff(input int blk);
    return (blk == 0) ? 1 : blk;
  endfunction

  function automatic int nblocks(input int cnt, input int blk);
    return (cnt + eff(blk) - 1) / eff(blk);
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0103);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic program_ch(input int src, input int dst, input int blk, input int cnt, input bit em);
    cfg_write(K_CTRL, 16'd0);
    cfg_write(K_SRC, 16'(src));
    cfg_write(K_DST, 16'(dst));
    cfg_write(K_BLK, 16'(blk));
    cfg_write(K_CNT, 16'(cnt));
    cfg_write(K_CTRL, {14'd0, em, 1'b1});
  endtask

  task automatic pulse;
    @(posedge clk); #1 dreq = 1'b1;
    @(posedge clk); #1 dreq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wait_block(input string tag);
    int b0;
    int n;
    b0 = blocks;
    n = 0;
    while (blocks == b0 && n < 500) begin
      @(posedge clk); #3;
      n++;
    end
    check(blocks != b0, tag, "block completes", blocks - b0, 1);
  endtask

  task automatic init_mem;
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? pat(i) : 32'd0;
  endtask

  task automatic check_copy(input string tag, input int si, input int di, input int cnt);
    int bad;
    bad = 0;
    for (int i = 0; i < cnt; i++) if (mem[di + i] !== pat(si + i)) bad++;
    check(bad == 0, tag, "destination words equal source words", bad, 0);
  endtask

  // grant follows request; random acknowledge
  always begin
    @(posedge clk); #1;
    bus_gnt = gnt_hold ? 1'b0 : bus_req;
    bus_ack = ($urandom % 4) != 0;
  end

  // monitor and bus memory model
  always begin
    @(posedge clk); #2;
    if (!rst_n) begin
      prev_dack = 1'b0;
      prev_req  = 1'b0;
    end else begin
      if (dack && !prev_dack) begin
        blk_units  = 0;
        first_pend = 1'b1;
        check(!bus_rd && !bus_wr, "R5", "no access in descriptor cycle", {bus_rd, bus_wr}, 0);
      end
      if (bus_rd || bus_wr) acc_cnt++;
      if (bus_rd && bus_ack && first_pend) begin
        blk_first  = bus_addr;
        first_pend = 1'b0;
      end
      if (bus_wr && bus_ack) begin
        mem[bus_addr[9:2]] = bus_wdata;
        blk_units++;
        tot_units++;
      end
      if (!dack && prev_dack) begin
        blocks++;
        last_units = blk_units;
        last_first = blk_first;
        check(!bus_req, "R3", "bus released as block ends", bus_req, 0);
      end
      if (bus_req && !prev_req) req_rises++;
      prev_dack = dack;
      prev_req  = bus_req;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int b0, r0, a0, u0, rem, nb, n, exp_u;
    int blk, cnt, si, di;
    bit em;
    void'($urandom(32'h3C5A_7E11));
    init_mem();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // reset state
    check(!bus_req && !dack, "R5", "reset: no request, no dack", {bus_req, dack}, 0);
    check(!busy && !done, "R9", "reset: not busy, not done", {busy, done}, 0);

    // R1: one edge, one block, then quiet
    program_ch(16'h0000, 16'h0200, 2, 6, 1'b1);
    b0 = blocks; r0 = req_rises;
    pulse();
    wait_block("R1");
    check(last_units == 2, "R4", "units in first block", last_units, 2);
    check(last_first == 16'h0000, "R10", "first source address", last_first, 0);
    idle(10);
    check(blocks - b0 == 1, "R1", "single block per edge", blocks - b0, 1);
    check(req_rises - r0 == 1, "R1", "no new bus request", req_rises - r0, 1);

    // R6 / R9: withheld grant, blocked write
    gnt_hold = 1'b1;
    a0 = acc_cnt;
    pulse();
    idle(15);
    check(bus_req && !dack, "R6", "waiting for grant", {bus_req, dack}, 2);
    check(acc_cnt == a0, "R6", "no access without grant", acc_cnt - a0, 0);
    check(busy, "R9", "busy while request pending", busy, 1);
    cfg_write(K_SRC, 16'h0100);
    gnt_hold = 1'b0;
    wait_block("R6");
    check(last_first == 16'h0008, "R9", "source continues after blocked write", last_first, 8);
    check(last_units == 2, "R4", "units in second block", last_units, 2);
    idle(2);
    check_copy("R10", 0, 128, 4);

    // R7: edges during a block merge into one more block
    init_mem();
    program_ch(16'h0040, 16'h0280, 4, 12, 1'b1);
    b0 = blocks;
    pulse();
    n = 0;
    while (!dack && n < 100) begin @(posedge clk); #3; n++; end
    pulse();
    pulse();
    wait_block("R7");
    wait_block("R7");
    idle(15);
    check(blocks - b0 == 2, "R7", "merged edges give one extra block", blocks - b0, 2);
    check(!done, "R8", "count not yet used up", done, 0);

    // R8: last block, completion, ignored request
    pulse();
    wait_block("R8");
    check(last_first == 16'h0060, "R10", "third block source address", last_first, 16'h60);
    idle(2);
    check(done, "R8", "done after count reaches zero", done, 1);
    check_copy("R10", 16, 160, 12);
    b0 = blocks; r0 = req_rises;
    pulse();
    idle(15);
    check(blocks == b0 && req_rises == r0, "R8", "request ignored after done", req_rises - r0, 0);
    cfg_write(K_CTRL, 16'd3);
    idle(1);
    check(!done, "R11", "control write clears done", done, 0);

    // R2: level mode runs blocks until done, releasing between them
    init_mem();
    program_ch(16'h0080, 16'h0300, 3, 7, 1'b0);
    b0 = blocks; r0 = req_rises;
    @(posedge clk); #1 dreq = 1'b1;
    n = 0;
    while (!done && n < 3000) begin @(posedge clk); #3; n++; end
    idle(10);
    check(blocks - b0 == 3, "R2", "level mode block count", blocks - b0, 3);
    check(last_units == 1, "R4", "last block capped by count", last_units, 1);
    check(req_rises - r0 == 3, "R3", "separate bus request per block", req_rises - r0, 3);
    @(posedge clk); #1 dreq = 1'b0;
    check_copy("R10", 32, 192, 7);

    // R4: block size zero moves one unit
    program_ch(16'h0000, 16'h03C0, 0, 2, 1'b1);
    pulse();
    wait_block("R4");
    check(last_units == 1, "R4", "block size zero moves one unit", last_units, 1);

    // random configurations
    for (int it = 0; it < 24; it++) begin
      blk = $urandom % 4;
      cnt = 1 + ($urandom % 10);
      em  = 1'($urandom % 2);
      si  = $urandom % 16;
      di  = $urandom % 16;
      init_mem();
      program_ch(si * 4, 16'h0200 + di * 4, blk, cnt, em);
      b0 = blocks; u0 = tot_units;
      nb = nblocks(cnt, blk);
      if (em) begin
        rem = cnt;
        for (int k = 0; k < nb; k++) begin
          exp_u = (eff(blk) < rem) ? eff(blk) : rem;
          pulse();
          wait_block("R1");
          check(last_units == exp_u, "R4", "units per block", last_units, exp_u);
          check(last_first == 16'(si * 4 + 4 * (cnt - rem)), "R10", "block source address",
                last_first, si * 4 + 4 * (cnt - rem));
          rem -= exp_u;
        end
        idle(3);
      end else begin
        @(posedge clk); #1 dreq = 1'b1;
        n = 0;
        while (!done && n < 3000) begin @(posedge clk); #3; n++; end
        idle(8);
        @(posedge clk); #1 dreq = 1'b0;
        idle(1);
        check(blocks - b0 == nb, "R2", "level mode block count", blocks - b0, nb);
      end
      check(done, "R8", "done after random run", done, 1);
      check(tot_units - u0 == cnt, "R8", "total units equal count", tot_units - u0, cnt);
      check_copy("R10", si, 128 + di, cnt);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule